// File: doc/BRIEF.md
# CPU Bus Contention Clock Gate

This block sits beside an 8-bit CPU and decides when the CPU clock must be held because the display logic shares a region of RAM with the processor. Each cycle it looks at the address bus, the memory-request and IO-request strobes, a marker for the first T-state of an M-cycle and a video-busy window from the display timing. When an access falls in the shared 16 KiB window (address bits 15:14 equal to `01`) and that marker and the busy window are both high, it drops the CPU clock enable. It keeps the enable low until the busy window goes away. The delay pattern itself comes in as the busy window; this block does not generate it.

A small opcode-fetch bus model is built in. During the refresh half of a fetch (T3 and T4), it puts the interrupt-vector register on the high address byte and the refresh counter on the low byte, and it drives the memory-request and refresh strobes low. The contention decoder looks only at the memory-request strobe, so a vector register value from 0x40 to 0x7F makes the refresh phase look like a shared-RAM access. A stall may begin only on the first T-state, so this false match never stops the CPU. Instead it raises a one-cycle refresh-collision pulse, which models the display corruption that the collision causes.

Top module: `bus_contention_gate`

## Requirements
- R1: A memory access with `cpu_mreq_n` low and address bits 15:14 equal to `01` sets `contended` high on the next clock edge, whatever the T-state and the busy window.
- R2: With both `cpu_mreq_n` and `cpu_iorq_n` high and no refresh phase, an address inside the window leaves `contended` low.
- R3: When `t_first` is high, `fetch_refresh` is low, the access is contended and `video_busy` is high, `clk_en` goes low on the next clock edge.
- R4: A contended access seen while `t_first` is low never lowers `clk_en`.
- R5: Once stalled, `clk_en` stays low for every edge at which `video_busy` is sampled high. It returns high on the first edge at which `video_busy` is sampled low.
- R6: One edge after `fetch_refresh` is sampled high, `bus_addr` equals {`ireg`,`rreg`} and both `bus_mreq_n` and `bus_rfsh_n` are low. Otherwise the bus registers follow `cpu_addr` and `cpu_mreq_n`, with `bus_rfsh_n` high.
- R7: If `ireg` is from 0x40 to 0x7F, a refresh phase sets `contended`. `refresh_hit` pulses for exactly one cycle after the first refresh cycle, and `clk_en` stays high even when `video_busy` is high. With `ireg` outside that range, neither flag rises.
- R8: An IO access (`cpu_iorq_n` low) inside the window on the first T-state with `video_busy` high stalls the CPU as in R3. An IO access outside the window does not.
- R9: After a synchronous reset `clk_en` is 1, `contended` and `refresh_hit` are 0, `bus_addr` is 0, and `bus_mreq_n` and `bus_rfsh_n` are 1.
- R10: Addresses with bits 15:14 other than `01` (for example 0x3FFF, 0x8000, 0xC000) are never contended and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_iorq_n | input | 1 | IO request, active low |
| t_first | input | 1 | High in the first T-state of an M-cycle |
| fetch_refresh | input | 1 | High in T3/T4 of an opcode fetch |
| ireg | input | 8 | Interrupt-vector register value |
| rreg | input | 8 | Refresh counter value |
| video_busy | input | 1 | Display owns the shared RAM this cycle |
| clk_en | output | 1 | CPU clock enable, low while stalled |
| contended | output | 1 | Registered address-in-window flag |
| refresh_hit | output | 1 | One-cycle pulse on a refresh collision |
| bus_addr | output | 16 | Modelled bus address |
| bus_mreq_n | output | 1 | Modelled memory request |
| bus_rfsh_n | output | 1 | Modelled refresh strobe |

## Verification
A stall latch that gets stuck shows up at once: `clk_en` stays low on the edge after `video_busy` drops, or it falls on a cycle where `t_first` was low. A decoder that examined the refresh strobe, or an edge detector that lost its previous-phase bit, would show on the very next edge. The first case shows as a missing `contended` during refresh. The second shows as a missing or repeated `refresh_hit`. Each registered output is compared every cycle against a reference model, so any such error appears one clock after its cause.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int TAG_W   = 2;
  localparam logic [TAG_W-1:0] SHARED_TAG = 2'b01;

  function automatic logic in_shared(input logic [TAG_W-1:0] tag);
    return tag == SHARED_TAG;
  endfunction
endpackage

// File: rtl/bcg_bus_model.sv
module bcg_bus_model #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_mreq_n,
  input  logic          fetch_refresh,
  input  logic [BW-1:0] ireg,
  input  logic [BW-1:0] rreg,
  output logic [AW-1:0] eff_addr,
  output logic          eff_mreq_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mreq_n,
  output logic          bus_rfsh_n
);
  localparam int HI_W = AW - BW;

  logic [HI_W-1:0] hi_byte;

  generate
    if (HI_W == BW) begin : g_same
      assign hi_byte = ireg;
    end else begin : g_pad
      assign hi_byte = HI_W'(ireg);
    end
  endgenerate

  always_comb begin
    if (fetch_refresh) begin
      eff_addr   = {hi_byte, rreg};
      eff_mreq_n = 1'b0;
    end else begin
      eff_addr   = cpu_addr;
      eff_mreq_n = cpu_mreq_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr   <= '0;
      bus_mreq_n <= 1'b1;
      bus_rfsh_n <= 1'b1;
    end else begin
      bus_addr   <= eff_addr;
      bus_mreq_n <= eff_mreq_n;
      bus_rfsh_n <= ~fetch_refresh;
    end
  end
endmodule

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
(
  input  logic [TAG_W-1:0] eff_tag,
  input  logic             eff_mreq_n,
  input  logic             cpu_iorq_n,
  input  logic             fetch_refresh,
  output logic             hit
);
  logic win;
  logic io_req;

  assign win    = in_shared(eff_tag);
  assign io_req = ~cpu_iorq_n & ~fetch_refresh;
  assign hit    = win & (~eff_mreq_n | io_req);
endmodule

// File: rtl/bcg_stall_ctrl.sv
module bcg_stall_ctrl #(
  parameter int BW = 8,
  parameter int TW = 2,
  parameter logic [TW-1:0] TAG = 2'b01
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          t_first,
  input  logic          fetch_refresh,
  input  logic          video_busy,
  input  logic [BW-1:0] ireg,
  output logic          clk_en,
  output logic          contended,
  output logic          refresh_hit
);
  logic stall_q;
  logic prev_refresh;
  logic stall_start;
  logic stall_next;
  logic vec_in_window;

  assign vec_in_window = ireg[BW-1 -: TW] == TAG;
  assign stall_start   = t_first & ~fetch_refresh & hit & video_busy;
  assign stall_next    = stall_q ? video_busy : stall_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q      <= 1'b0;
      prev_refresh <= 1'b0;
      clk_en       <= 1'b1;
      contended    <= 1'b0;
      refresh_hit  <= 1'b0;
    end else begin
      stall_q      <= stall_next;
      prev_refresh <= fetch_refresh;
      clk_en       <= ~stall_next;
      contended    <= hit;
      refresh_hit  <= fetch_refresh & ~prev_refresh & vec_in_window;
    end
  end
endmodule

// File: rtl/bus_contention_gate.sv
module bus_contention_gate
  import bcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_mreq_n,
  input  logic              cpu_iorq_n,
  input  logic              t_first,
  input  logic              fetch_refresh,
  input  logic [BYTE_W-1:0] ireg,
  input  logic [BYTE_W-1:0] rreg,
  input  logic              video_busy,
  output logic              clk_en,
  output logic              contended,
  output logic              refresh_hit,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_mreq_n,
  output logic              bus_rfsh_n
);
  logic [ADDR_W-1:0] eff_addr;
  logic              eff_mreq_n;
  logic              hit;

  bcg_bus_model #(.AW(ADDR_W), .BW(BYTE_W)) u_bus (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mreq_n(cpu_mreq_n),
    .fetch_refresh(fetch_refresh), .ireg(ireg), .rreg(rreg),
    .eff_addr(eff_addr), .eff_mreq_n(eff_mreq_n),
    .bus_addr(bus_addr), .bus_mreq_n(bus_mreq_n), .bus_rfsh_n(bus_rfsh_n)
  );

  bcg_decode u_dec (
    .eff_tag(eff_addr[ADDR_W-1 -: TAG_W]), .eff_mreq_n(eff_mreq_n),
    .cpu_iorq_n(cpu_iorq_n), .fetch_refresh(fetch_refresh), .hit(hit)
  );

  bcg_stall_ctrl #(.BW(BYTE_W), .TW(TAG_W), .TAG(SHARED_TAG)) u_stall (
    .clk(clk), .rst(rst), .hit(hit), .t_first(t_first),
    .fetch_refresh(fetch_refresh), .video_busy(video_busy), .ireg(ireg),
    .clk_en(clk_en), .contended(contended), .refresh_hit(refresh_hit)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker (
  input logic       clk,
  input logic       rst,
  input logic       t_first,
  input logic       fetch_refresh,
  input logic [7:0] ireg,
  input logic       video_busy,
  input logic       clk_en,
  input logic       refresh_hit,
  input logic       bus_mreq_n,
  input logic       bus_rfsh_n
);
  // R3 / R4: a stall begins only on a first T-state outside refresh
  p_stall_first_t_r4: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && $past(clk_en)) |-> $past(t_first && !fetch_refresh && video_busy));

  // R5: release on the first cycle the busy window is gone
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !video_busy) |=> clk_en);

  // R6: refresh phase drives both strobes low on the modelled bus
  p_refresh_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_refresh |=> (!bus_mreq_n && !bus_rfsh_n));

  // R7: a collision pulse needs a refresh with the vector in the window
  p_hit_cause_r7: assert property (@(posedge clk) disable iff (rst)
    refresh_hit |-> ($past(fetch_refresh) && $past(ireg[7:6] == 2'b01)));

  // R7: the collision pulse lasts a single cycle
  p_hit_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    refresh_hit |=> !refresh_hit);
endmodule

bind bus_contention_gate bcg_checker u_chk (
  .clk(clk), .rst(rst), .t_first(t_first), .fetch_refresh(fetch_refresh),
  .ireg(ireg), .video_busy(video_busy), .clk_en(clk_en),
  .refresh_hit(refresh_hit), .bus_mreq_n(bus_mreq_n), .bus_rfsh_n(bus_rfsh_n)
);

// File: tb/bus_contention_gate_test.sv
module bus_contention_gate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_mreq_n = 1'b1, cpu_iorq_n = 1'b1;
  logic        t_first = 1'b0, fetch_refresh = 1'b0, video_busy = 1'b0;
  logic [7:0]  ireg = '0, rreg = '0;
  logic        clk_en, contended, refresh_hit, bus_mreq_n, bus_rfsh_n;
  logic [15:0] bus_addr;

  always #4 clk = ~clk;

  bus_contention_gate uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mreq_n(cpu_mreq_n),
    .cpu_iorq_n(cpu_iorq_n), .t_first(t_first), .fetch_refresh(fetch_refresh),
    .ireg(ireg), .rreg(rreg), .video_busy(video_busy), .clk_en(clk_en),
    .contended(contended), .refresh_hit(refresh_hit), .bus_addr(bus_addr),
    .bus_mreq_n(bus_mreq_n), .bus_rfsh_n(bus_rfsh_n)
  );

  typedef struct {
    logic [20:0] v;   // {clk_en, contended, refresh_hit, bus_addr, mreq_n, rfsh_n}
    string       tag;
  } exp_t;

  exp_t q[$];
  int   applied = 0, miscompares = 0;
  logic m_stall = 0, m_prev = 0;
  int   stall_count = 0;

  // driver: apply one cycle of stimulus and predict the registered result
  task automatic drive(input logic r, input logic [15:0] a, input logic mq,
                       input logic io, input logic tf, input logic fr,
                       input logic [7:0] ir, input logic [7:0] rr,
                       input logic vb, input string tag);
    exp_t e;
    logic [15:0] ea;
    logic em, hit, st, rh;
    @(negedge clk);
    rst = r; cpu_addr = a; cpu_mreq_n = mq; cpu_iorq_n = io; t_first = tf;
    fetch_refresh = fr; ireg = ir; rreg = rr; video_busy = vb;
    if (r) begin
      m_stall = 0; m_prev = 0;
      e.v = {1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1};
    end else begin
      ea  = fr ? {ir, rr} : a;
      em  = fr ? 1'b0 : mq;
      hit = (ea[15:14] == 2'b01) && (!em || (!fr && !io));
      rh  = fr && !m_prev && (ir >= 8'h40) && (ir <= 8'h7F);
      st  = m_stall ? vb : (tf && !fr && hit && vb);
      if (st) stall_count++;
      m_stall = st; m_prev = fr;
      e.v = {!st, hit, rh, ea, em, !fr};
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, 16'h8000, 1, 1, 0, 0, 8'h00, 8'h00, 0, tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [20:0] act;
      e = q.pop_front();
      act = {clk_en, contended, refresh_hit, bus_addr, bus_mreq_n, bus_rfsh_n};
      applied++;
      if (act !== e.v) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", e.tag, act, e.v);
      end
    end
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    drive(1, 16'h4000, 0, 0, 1, 0, 8'h55, 8'h11, 1, "R9 reset");
    drive(1, 16'h0000, 1, 1, 0, 0, 8'h00, 8'h00, 0, "R9 reset");
    // R10: outside window, first T, busy
    drive(0, 16'h3FFF, 0, 1, 1, 0, 8'h00, 8'h00, 1, "R10 0x3FFF");
    drive(0, 16'h8000, 0, 1, 1, 0, 8'h00, 8'h00, 1, "R10 0x8000");
    drive(0, 16'hC000, 0, 1, 1, 0, 8'h00, 8'h00, 1, "R10 0xC000");
    // R1: contended flag without busy
    drive(0, 16'h4000, 0, 1, 1, 0, 8'h00, 8'h00, 0, "R1 mem 0x4000");
    drive(0, 16'h7FFF, 0, 1, 0, 0, 8'h00, 8'h00, 0, "R1 mem 0x7FFF later T");
    // R2: no strobe
    drive(0, 16'h5000, 1, 1, 1, 0, 8'h00, 8'h00, 1, "R2 no strobe");
    // R4: later T-state with busy
    drive(0, 16'h6000, 0, 1, 0, 0, 8'h00, 8'h00, 1, "R4 later T");
    drive(0, 16'h6000, 0, 1, 0, 0, 8'h00, 8'h00, 1, "R4 later T");
    // R3 / R5: stall and hold
    drive(0, 16'h5A00, 0, 1, 1, 0, 8'h00, 8'h00, 1, "R3 stall start");
    for (int i = 0; i < 3; i++)
      drive(0, 16'h5A00, 0, 1, 0, 0, 8'h00, 8'h00, 1, "R5 stall hold");
    drive(0, 16'h5A00, 0, 1, 0, 0, 8'h00, 8'h00, 0, "R5 release");
    idle("R5 after release");
    // R7 / R6: refresh with vector in window, busy high
    drive(0, 16'h4100, 0, 1, 1, 0, 8'h63, 8'h2A, 0, "R6 fetch T1");
    drive(0, 16'h4100, 0, 1, 0, 0, 8'h63, 8'h2A, 1, "R6 fetch T2");
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h63, 8'h2A, 1, "R7 refresh T3");
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h63, 8'h2B, 1, "R7 refresh T4");
    idle("R7 after refresh");
    // R7: vector outside window
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h20, 8'h2C, 1, "R7 vector 0x20");
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h80, 8'h2D, 1, "R7 vector 0x80");
    idle("R7 idle");
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h40, 8'h2E, 0, "R7 vector 0x40");
    drive(0, 16'h0000, 1, 1, 0, 1, 8'h7F, 8'h2F, 0, "R7 vector 0x7F");
    idle("R7 idle");
    // R8: IO contention
    drive(0, 16'h40FE, 1, 0, 1, 0, 8'h00, 8'h00, 1, "R8 io stall");
    drive(0, 16'h40FE, 1, 0, 0, 0, 8'h00, 8'h00, 1, "R8 io hold");
    drive(0, 16'h40FE, 1, 0, 0, 0, 8'h00, 8'h00, 0, "R8 io release");
    drive(0, 16'h80FE, 1, 0, 1, 0, 8'h00, 8'h00, 1, "R8 io outside");
    drive(0, 16'h00FE, 1, 0, 1, 0, 8'h00, 8'h00, 1, "R8 io outside low");
    idle("R8 idle");
    // mixed sweep
    for (int i = 0; i < 64; i++)
      drive(0, {i[1:0], i[5:2], 10'h015}, i[0], i[1], i[2], i[3] & i[4],
            {i[5:4], 6'h05}, i[7:0], i[2] ^ i[5], "R3 R5 sweep");
    idle("sweep end");
    @(negedge clk);
    @(negedge clk);
    if (stall_count == 0) begin
      miscompares++;
      $display("FAIL R3 stall count: got %0d expected nonzero", stall_count);
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule